// File: doc/BRIEF.md
# SPI Master Burst Engine

This block is an SPI master that moves a whole burst of bytes under one start command. Software sets the total number of bytes to clock and, separately, how many of them are taken from an 8-bit transmit FIFO. After the transmit share is used up, the engine keeps clocking and sends zero bytes, so a command can be followed by a read phase without the software having to stuff filler bytes. Received bytes land in a receive FIFO. An optional mode drops the bytes that arrive while real transmit data is going out, so a write-only phase does not pollute the receive FIFO.

The serial clock advances one half period per pulse of an external divider strobe. Clock polarity, sampling phase and bit order are selectable. Four select lines are driven either automatically around the burst or directly from a level bit, with a selectable active polarity. A transfer-complete flag and a receive-overflow flag feed one interrupt line through enable bits. Software reaches all of this through a word-addressed register port.

Top module: `spi_burst_master`

## Requirements
- R1: After reset the transfer-control register (word 1) and FIFO status register (word 5) read 0, every select line is high, SCLK and MOSI are low and the interrupt is low.
- R2: A write to word 8 pushes its low byte into the transmit FIFO; a read of word 9 returns and removes the receive FIFO head. Word 5 holds the receive fill level from bit 0 and the transmit fill level from bit 16, each $clog2(DEPTH+1) bits wide.
- R3: SCLK idles at transfer-control bit 1 (CPOL). With bit 0 (CPHA) clear, data is sampled on the leading edge, otherwise on the trailing edge; bit 12 set sends and receives LSB first. Each byte produces exactly 8 sample edges, and with MISO tied to MOSI each received byte equals the sent byte.
- R4: A burst clocks exactly the count in word 6; the first count-in-word-7 bytes come from the transmit FIFO and each later byte sends 0x00.
- R5: With transfer-control bit 8 set, bytes clocked while transmit-FIFO data is being sent are not written to the receive FIFO; dummy-phase bytes still are.
- R6: Writing 1 to transfer-control bit 31 starts a burst only when global-control (word 0) bit 0 is set; bit 31 reads 1 while the burst runs and clears on the same clock edge that sets interrupt-status (word 3) bit 12.
- R7: When the transmit FIFO is empty before the transmit count is reached, SCLK holds its idle level and the burst resumes once a byte is written.
- R8: With global-control bit 7 set, no new byte starts; SCLK changes only on clock edges where tick_i is high.
- R9: Transfer-control bits 5:4 select one line. Bit 2 set makes the select active-high, clear makes it active-low. In automatic mode the selected line is active while the burst runs; with bit 6 set it is driven to bit 7 instead. Unselected lines stay inactive.
- R10: A byte completed while the receive FIFO is full is dropped and sets interrupt-status bit 8.
- R11: irq_o is high while any interrupt-status bit is set together with the same bit of the enable register (word 2); writing 1 to a status bit clears it.
- R12: Writing 1 to FIFO-control (word 4) bit 15 empties the receive FIFO, bit 31 empties the transmit FIFO.
- R13: Writing 1 to global-control bit 31 returns every register, both FIFOs and the shifter to their reset state; the bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | AW | Register word address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (pops RX FIFO at word 9) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from address |
| tick_i | input | 1 | Divider strobe, one SCLK half period per pulse |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_o | output | 4 | Chip-select lines |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with DEPTH set to 8 and the default 24-bit counters, so a ten-byte dummy burst overruns the receive FIFO within a few hundred cycles and the overflow flag, full-FIFO drop and 4-bit fill-level fields become reachable. All eight combinations of polarity, phase and bit order run through a looped-back MISO while a serial monitor checks the edge count and bit order on MOSI. Directed cases then cover dummy fill, receive discard, transmit starvation, pause, strobe gating, select control and the two reset paths.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;
  // register word addresses
  localparam int unsigned A_GCTL = 0;
  localparam int unsigned A_XCTL = 1;
  localparam int unsigned A_IEN  = 2;
  localparam int unsigned A_ISTA = 3;
  localparam int unsigned A_FCTL = 4;
  localparam int unsigned A_FSTA = 5;
  localparam int unsigned A_BCNT = 6;
  localparam int unsigned A_TCNT = 7;
  localparam int unsigned A_TXD  = 8;
  localparam int unsigned A_RXD  = 9;

  localparam int unsigned B_TC   = 12;
  localparam int unsigned B_OVF  = 8;
  localparam int unsigned B_RXCLR = 15;
  localparam int unsigned B_TXCLR = 31;

  typedef struct packed {
    logic       lsb;
    logic       dhb;
    logic       cs_lvl;
    logic       cs_man;
    logic [1:0] cs_sel;
    logic       spol;
    logic       cpol;
    logic       cpha;
  } xctl_t;
endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int DEPTH = 128,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  dout_o,
  output logic [CW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full_o  = (level_o == CW'(DEPTH));
  assign empty_o = (level_o == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = mem[rp];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp <= '0; rp <= '0; level_o <= '0;
    end else if (clr_i) begin
      wp <= '0; rp <= '0; level_o <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      case ({do_push, do_pop})
        2'b10:   level_o <= level_o + 1'b1;
        2'b01:   level_o <= level_o - 1'b1;
        default: level_o <= level_o;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp] <= din_i;
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             abort_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] burst_cnt_i,
  input  logic [CNT_W-1:0] tx_cnt_i,
  input  logic             cpha_i,
  input  logic             lsb_i,
  input  logic             dhb_i,
  input  logic             pause_i,
  input  logic             tick_i,
  input  logic [7:0]       tx_data_i,
  input  logic             tx_empty_i,
  input  logic             miso_i,
  output logic             tx_pop_o,
  output logic             rx_push_o,
  output logic [7:0]       rx_data_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             sclk_act_o,
  output logic             mosi_o
);
  logic             loaded, half, in_tx;
  logic [2:0]       bit_cnt;
  logic [CNT_W-1:0] byte_left, tx_left;
  logic [7:0]       sh_tx, sh_rx;
  logic             need_tx, can_load, last_edge;

  function automatic logic [7:0] ins(input logic [7:0] sh, input logic b, input logic lsb);
    return lsb ? {b, sh[7:1]} : {sh[6:0], b};
  endfunction

  function automatic logic [7:0] shl(input logic [7:0] sh, input logic lsb);
    return lsb ? {1'b0, sh[7:1]} : {sh[6:0], 1'b0};
  endfunction

  assign need_tx    = (tx_left != '0);
  assign can_load   = !pause_i && (!need_tx || !tx_empty_i);
  assign tx_pop_o   = busy_o && !loaded && (byte_left != '0) && can_load && need_tx;
  assign done_o     = busy_o && !loaded && (byte_left == '0);
  assign last_edge  = busy_o && loaded && tick_i && half && (bit_cnt == 3'd7);
  assign rx_data_o  = cpha_i ? ins(sh_rx, miso_i, lsb_i) : sh_rx;
  assign rx_push_o  = last_edge && !(dhb_i && in_tx);
  assign sclk_act_o = busy_o && loaded && half;
  assign mosi_o     = lsb_i ? sh_tx[0] : sh_tx[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0; loaded <= 1'b0; half <= 1'b0; in_tx <= 1'b0;
      bit_cnt <= '0; byte_left <= '0; tx_left <= '0; sh_tx <= '0; sh_rx <= '0;
    end else if (abort_i) begin
      busy_o <= 1'b0; loaded <= 1'b0; half <= 1'b0; in_tx <= 1'b0;
      bit_cnt <= '0; byte_left <= '0; tx_left <= '0; sh_tx <= '0; sh_rx <= '0;
    end else if (!busy_o) begin
      if (start_i) begin
        busy_o    <= 1'b1;
        loaded    <= 1'b0;
        byte_left <= burst_cnt_i;
        tx_left   <= tx_cnt_i;
      end
    end else if (!loaded) begin
      if (byte_left == '0) begin
        busy_o <= 1'b0;
        sh_tx  <= '0;
      end else if (can_load) begin
        loaded  <= 1'b1;
        half    <= 1'b0;
        bit_cnt <= '0;
        in_tx   <= need_tx;
        sh_tx   <= need_tx ? tx_data_i : 8'h00;
        if (need_tx) tx_left <= tx_left - 1'b1;
      end
    end else if (tick_i) begin
      if (!half) begin
        half <= 1'b1;
        if (!cpha_i)              sh_rx <= ins(sh_rx, miso_i, lsb_i);
        else if (bit_cnt != 3'd0) sh_tx <= shl(sh_tx, lsb_i);
      end else begin
        half <= 1'b0;
        if (cpha_i) sh_rx <= ins(sh_rx, miso_i, lsb_i);
        if (bit_cnt == 3'd7) begin
          loaded    <= 1'b0;
          byte_left <= byte_left - 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
          if (!cpha_i) sh_tx <= shl(sh_tx, lsb_i);
        end
      end
    end
  end
endmodule

// File: rtl/spi_burst_master.sv
module spi_burst_master
  import spi_burst_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int CNT_W = 24,
  parameter int AW    = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] reg_addr_i,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  input  logic          tick_i,
  output logic          sclk_o,
  output logic          mosi_o,
  input  logic          miso_i,
  output logic [3:0]    cs_o,
  output logic          irq_o
);
  xctl_t            xc;
  logic             g_en, g_master, g_pause;
  logic             ien_tc, ien_ovf, sts_tc, sts_ovf;
  logic [CNT_W-1:0] bcnt, tcnt;
  logic             sreset, start, wr_x, wr_s, wr_f;
  logic             busy_w, done_w, sclk_act, cpol_w, spol_w;
  logic             tx_pop, tx_empty, tx_full, rx_push, rx_full, rx_empty;
  logic [7:0]       tx_head, rx_byte, rx_head;
  logic [CW-1:0]    tx_level, rx_level;

  function automatic logic hit(input logic [AW-1:0] a, input int unsigned w);
    return a == AW'(w);
  endfunction

  assign sreset = reg_wr_i && hit(reg_addr_i, A_GCTL) && reg_wdata_i[31];
  assign wr_x   = reg_wr_i && hit(reg_addr_i, A_XCTL);
  assign wr_s   = reg_wr_i && hit(reg_addr_i, A_ISTA);
  assign wr_f   = reg_wr_i && hit(reg_addr_i, A_FCTL);
  assign start  = wr_x && reg_wdata_i[31] && g_en && !busy_w;
  assign cpol_w = xc.cpol;
  assign spol_w = xc.spol;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xc <= '0; g_en <= 1'b0; g_master <= 1'b0; g_pause <= 1'b0;
      ien_tc <= 1'b0; ien_ovf <= 1'b0; sts_tc <= 1'b0; sts_ovf <= 1'b0;
      bcnt <= '0; tcnt <= '0;
    end else if (sreset) begin
      xc <= '0; g_en <= 1'b0; g_master <= 1'b0; g_pause <= 1'b0;
      ien_tc <= 1'b0; ien_ovf <= 1'b0; sts_tc <= 1'b0; sts_ovf <= 1'b0;
      bcnt <= '0; tcnt <= '0;
    end else begin
      if (reg_wr_i && hit(reg_addr_i, A_GCTL)) begin
        g_en <= reg_wdata_i[0]; g_master <= reg_wdata_i[1]; g_pause <= reg_wdata_i[7];
      end
      if (wr_x)
        xc <= '{lsb: reg_wdata_i[12], dhb: reg_wdata_i[8], cs_lvl: reg_wdata_i[7],
                cs_man: reg_wdata_i[6], cs_sel: reg_wdata_i[5:4], spol: reg_wdata_i[2],
                cpol: reg_wdata_i[1], cpha: reg_wdata_i[0]};
      if (reg_wr_i && hit(reg_addr_i, A_IEN)) begin
        ien_tc <= reg_wdata_i[B_TC]; ien_ovf <= reg_wdata_i[B_OVF];
      end
      if (reg_wr_i && hit(reg_addr_i, A_BCNT)) bcnt <= reg_wdata_i[CNT_W-1:0];
      if (reg_wr_i && hit(reg_addr_i, A_TCNT)) tcnt <= reg_wdata_i[CNT_W-1:0];
      // set wins over a simultaneous clear
      sts_tc  <= done_w || (sts_tc && !(wr_s && reg_wdata_i[B_TC]));
      sts_ovf <= (rx_push && rx_full) || (sts_ovf && !(wr_s && reg_wdata_i[B_OVF]));
    end
  end

  spi_byte_fifo #(.DEPTH(DEPTH), .W(8)) u_txf (
    .clk_i, .rst_ni,
    .clr_i  (sreset || (wr_f && reg_wdata_i[B_TXCLR])),
    .push_i (reg_wr_i && hit(reg_addr_i, A_TXD)),
    .din_i  (reg_wdata_i[7:0]),
    .pop_i  (tx_pop),
    .dout_o (tx_head),
    .level_o(tx_level),
    .full_o (tx_full),
    .empty_o(tx_empty)
  );

  spi_byte_fifo #(.DEPTH(DEPTH), .W(8)) u_rxf (
    .clk_i, .rst_ni,
    .clr_i  (sreset || (wr_f && reg_wdata_i[B_RXCLR])),
    .push_i (rx_push),
    .din_i  (rx_byte),
    .pop_i  (reg_rd_i && hit(reg_addr_i, A_RXD)),
    .dout_o (rx_head),
    .level_o(rx_level),
    .full_o (rx_full),
    .empty_o(rx_empty)
  );

  spi_shift_engine #(.CNT_W(CNT_W)) u_eng (
    .clk_i, .rst_ni,
    .abort_i    (sreset),
    .start_i    (start),
    .burst_cnt_i(bcnt),
    .tx_cnt_i   (tcnt),
    .cpha_i     (xc.cpha),
    .lsb_i      (xc.lsb),
    .dhb_i      (xc.dhb),
    .pause_i    (g_pause),
    .tick_i,
    .tx_data_i  (tx_head),
    .tx_empty_i (tx_empty),
    .miso_i,
    .tx_pop_o   (tx_pop),
    .rx_push_o  (rx_push),
    .rx_data_o  (rx_byte),
    .busy_o     (busy_w),
    .done_o     (done_w),
    .sclk_act_o (sclk_act),
    .mosi_o
  );

  assign sclk_o = xc.cpol ^ sclk_act;
  assign irq_o  = (sts_tc && ien_tc) || (sts_ovf && ien_ovf);

  for (genvar i = 0; i < 4; i++) begin : g_cs
    always_comb begin
      if (xc.cs_sel != 2'(i)) cs_o[i] = ~xc.spol;
      else if (xc.cs_man)     cs_o[i] = xc.cs_lvl;
      else                    cs_o[i] = busy_w ? xc.spol : ~xc.spol;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      AW'(A_GCTL): begin
        reg_rdata_o[0] = g_en; reg_rdata_o[1] = g_master; reg_rdata_o[7] = g_pause;
      end
      AW'(A_XCTL): begin
        reg_rdata_o[31] = busy_w;   reg_rdata_o[12]  = xc.lsb;
        reg_rdata_o[8]  = xc.dhb;   reg_rdata_o[7]   = xc.cs_lvl;
        reg_rdata_o[6]  = xc.cs_man; reg_rdata_o[5:4] = xc.cs_sel;
        reg_rdata_o[2]  = xc.spol;  reg_rdata_o[1]   = xc.cpol;
        reg_rdata_o[0]  = xc.cpha;
      end
      AW'(A_IEN):  begin reg_rdata_o[B_TC] = ien_tc; reg_rdata_o[B_OVF] = ien_ovf; end
      AW'(A_ISTA): begin reg_rdata_o[B_TC] = sts_tc; reg_rdata_o[B_OVF] = sts_ovf; end
      AW'(A_FSTA): begin
        reg_rdata_o[CW-1:0]  = rx_level;
        reg_rdata_o[16 +: CW] = tx_level;
      end
      AW'(A_BCNT): reg_rdata_o[CNT_W-1:0] = bcnt;
      AW'(A_TCNT): reg_rdata_o[CNT_W-1:0] = tcnt;
      AW'(A_RXD):  reg_rdata_o[7:0] = rx_head;
      default:     reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/spi_burst_master_chk.sv
module spi_burst_master_chk #(
  parameter int DEPTH = 128,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy,
  input logic          sts_tc,
  input logic          sts_ovf,
  input logic          sreset,
  input logic          sclk_o,
  input logic          cpol,
  input logic          spol,
  input logic [3:0]    cs_o,
  input logic          tick_i,
  input logic          reg_wr_i,
  input logic          rx_push,
  input logic          rx_full,
  input logic [CW-1:0] tx_level,
  input logic [CW-1:0] rx_level
);
  // R6
  xch_tc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy) && !$past(sreset)) |-> sts_tc);

  // R3
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (sclk_o == cpol));

  // R9
  cs_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cs_o ^ {4{~spol}}) <= 1);

  // R8
  sclk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !reg_wr_i) |=> $stable(sclk_o));

  // R10
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push && rx_full && !sreset) |=> sts_ovf);

  // R2
  level_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_level <= CW'(DEPTH)) && (rx_level <= CW'(DEPTH)));
endmodule

bind spi_burst_master spi_burst_master_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .busy     (busy_w),
  .sts_tc   (sts_tc),
  .sts_ovf  (sts_ovf),
  .sreset   (sreset),
  .sclk_o   (sclk_o),
  .cpol     (cpol_w),
  .spol     (spol_w),
  .cs_o     (cs_o),
  .tick_i   (tick_i),
  .reg_wr_i (reg_wr_i),
  .rx_push  (rx_push),
  .rx_full  (rx_full),
  .tx_level (tx_level),
  .rx_level (rx_level)
);

// File: tb/spi_burst_master_tb.sv
`timescale 1ns/1ps
module spi_burst_master_tb;
  localparam int DEPTH = 8;
  localparam int AW    = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0]   reg_wdata = '0, reg_rdata;
  logic          tick_en = 1'b1;
  logic          sclk, mosi, irq;
  logic [3:0]    cs;

  int checks = 0, failures = 0;
  int edges = 0;
  logic [7:0] mon = '0;
  logic prev_sclk = 1'b0;
  logic cur_cpol = 1'b0, cur_cpha = 1'b0;
  bit finished = 0;

  always #10 clk = ~clk;

  spi_burst_master #(.DEPTH(DEPTH), .CNT_W(24), .AW(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(reg_addr), .reg_wr_i(reg_wr),
    .reg_rd_i(reg_rd), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .tick_i(tick_en), .sclk_o(sclk), .mosi_o(mosi), .miso_i(mosi),
    .cs_o(cs), .irq_o(irq)
  );

  // serial monitor: records MOSI on every sample edge
  always @(negedge clk) begin
    if (sclk !== prev_sclk) begin
      if ((sclk != cur_cpol) != cur_cpha) begin
        mon   <= {mon[6:0], mosi};
        edges <= edges + 1;
      end
    end
    prev_sclk <= sclk;
  end

  typedef struct packed {
    logic [2:0] mode;   // {cpol, cpha, lsb}
    logic [7:0] dat;
    logic [7:0] ser;    // bits in wire order, first bit at [7]
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3'b000, 8'hA5, 8'hA5}, '{3'b010, 8'h3C, 8'h3C},
    '{3'b100, 8'hC6, 8'hC6}, '{3'b110, 8'h0F, 8'h0F},
    '{3'b001, 8'h1E, 8'h78}, '{3'b111, 8'h01, 8'h80},
    '{3'b011, 8'hB4, 8'h2D}, '{3'b101, 8'h40, 8'h02}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = AW'(a); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = AW'(a); reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    logic [31:0] d;
    for (int i = 0; i < 4000; i++) begin
      rd(1, d);
      if (!d[31]) return;
    end
    chk(1'b0, tag, 32'h1, 32'h0);
  endtask

  task automatic clr_fifos();
    wr(4, 32'h8000_8000);
    wr(3, 32'h0000_1100);
  endtask

  logic [31:0] d;
  int base;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(1, d); chk(d == 0, "R1 xctl", d, 0);
    rd(5, d); chk(d == 0, "R1 fsta", d, 0);
    chk(cs == 4'hF, "R1 cs", 32'(cs), 32'hF);
    chk(sclk == 0 && mosi == 0 && irq == 0, "R1 pins", {sclk, mosi, irq}, 0);

    // R6 start ignored while bus disabled
    wr(6, 1); wr(7, 0);
    base = edges;
    wr(1, 32'h8000_0000);
    repeat (20) @(negedge clk);
    rd(1, d); chk(d[31] == 0, "R6 disabled start", d, 0);
    rd(3, d); chk(d == 0, "R6 disabled no tc", d, 0);
    chk(edges == base, "R6 disabled no edges", edges - base, 0);

    wr(0, 32'h3);

    // R3 R2 mode table with looped-back MISO
    foreach (VECS[k]) begin
      logic [31:0] xv;
      xv = '0;
      xv[0] = VECS[k].mode[1]; xv[1] = VECS[k].mode[2]; xv[12] = VECS[k].mode[0];
      cur_cpol = VECS[k].mode[2]; cur_cpha = VECS[k].mode[1];
      wr(1, xv); wr(6, 1); wr(7, 1); wr(8, {24'h0, VECS[k].dat});
      rd(5, d); chk(d == 32'h0001_0000, "R2 tx level", d, 32'h0001_0000);
      base = edges;
      wr(1, xv | 32'h8000_0000);
      wait_done("R6 table burst timeout");
      chk(edges - base == 8, "R3 sample edges", edges - base, 8);
      chk(mon == VECS[k].ser, "R3 wire order", mon, VECS[k].ser);
      rd(3, d); chk(d[12] == 1, "R6 tc set", d, 32'h1000);
      rd(9, d); chk(d[7:0] == VECS[k].dat, "R2 loopback byte", d, VECS[k].dat);
      rd(5, d); chk(d == 0, "R2 fifos drained", d, 0);
      wr(3, 32'h1000);
    end

    cur_cpol = 0; cur_cpha = 0;
    wr(1, 32'h0);

    // R4 dummy fill
    wr(6, 3); wr(7, 1); wr(8, 32'h5A);
    wr(1, 32'h8000_0000);
    wait_done("R4 timeout");
    rd(5, d); chk(d == 3, "R4 rx level", d, 3);
    rd(9, d); chk(d == 32'h5A, "R4 byte0", d, 32'h5A);
    rd(9, d); chk(d == 0, "R4 dummy byte1", d, 0);
    rd(9, d); chk(d == 0, "R4 dummy byte2", d, 0);
    clr_fifos();

    // R5 discard during transmit phase
    wr(1, 32'h100);
    wr(6, 3); wr(7, 2); wr(8, 32'h11); wr(8, 32'h22);
    wr(1, 32'h8000_0100);
    wait_done("R5 timeout");
    rd(5, d); chk(d == 1, "R5 rx level", d, 1);
    rd(9, d); chk(d == 0, "R5 kept dummy", d, 0);
    wr(1, 32'h0); clr_fifos();

    // R7 stall on empty TX FIFO
    wr(6, 2); wr(7, 2); wr(8, 32'h77);
    base = edges;
    wr(1, 32'h8000_0000);
    repeat (60) @(negedge clk);
    rd(1, d); chk(d[31] == 1, "R7 still busy", d, 32'h8000_0000);
    chk(edges - base == 8, "R7 one byte only", edges - base, 8);
    chk(sclk == 0, "R7 sclk idle", 32'(sclk), 0);
    wr(8, 32'h88);
    wait_done("R7 timeout");
    chk(edges - base == 16, "R7 resumed", edges - base, 16);
    rd(9, d); rd(9, d); chk(d == 32'h88, "R7 second byte", d, 32'h88);
    clr_fifos();

    // R8 pause
    wr(0, 32'h83);
    wr(6, 1); wr(7, 0);
    base = edges;
    wr(1, 32'h8000_0000);
    repeat (40) @(negedge clk);
    rd(1, d); chk(d[31] == 1 && edges == base, "R8 paused", edges - base, 0);
    wr(0, 32'h3);
    wait_done("R8 pause timeout");
    chk(edges - base == 8, "R8 after pause", edges - base, 8);
    clr_fifos();

    // R8 strobe gating
    tick_en = 1'b0;
    base = edges;
    wr(1, 32'h8000_0000);
    repeat (30) @(negedge clk);
    chk(edges == base && sclk == 0, "R8 no tick", edges - base, 0);
    tick_en = 1'b1;
    wait_done("R8 tick timeout");
    chk(edges - base == 8, "R8 ticks resumed", edges - base, 8);
    clr_fifos();

    // R9 chip select
    wr(1, 32'h0000_0060);        // manual, level 0, line 2
    chk(cs == 4'b1011, "R9 manual low", 32'(cs), 32'hB);
    wr(1, 32'h0000_00E0);        // manual, level 1
    chk(cs == 4'hF, "R9 manual high", 32'(cs), 32'hF);
    wr(1, 32'h0000_0014);        // active-high, line 1, idle
    chk(cs == 4'h0, "R9 active-high idle", 32'(cs), 0);
    wr(1, 32'h0000_0010);
    wr(6, 2); wr(7, 0);
    wr(1, 32'h8000_0010);
    repeat (6) @(negedge clk);
    chk(cs == 4'b1101, "R9 auto active", 32'(cs), 32'hD);
    wait_done("R9 timeout");
    chk(cs == 4'hF, "R9 auto released", 32'(cs), 32'hF);
    wr(1, 32'h0); clr_fifos();

    // R10 overflow, R11 interrupt
    wr(6, DEPTH + 2); wr(7, 0);
    wr(1, 32'h8000_0000);
    wait_done("R10 timeout");
    rd(5, d); chk(d == DEPTH, "R10 rx full", d, DEPTH);
    rd(3, d); chk(d == 32'h1100, "R10 status", d, 32'h1100);
    chk(irq == 0, "R11 masked", 32'(irq), 0);
    wr(2, 32'h1000);
    chk(irq == 1, "R11 tc irq", 32'(irq), 1);
    wr(3, 32'h1000);
    chk(irq == 0, "R11 w1c", 32'(irq), 0);
    rd(3, d); chk(d == 32'h0100, "R11 ovf kept", d, 32'h0100);
    wr(2, 32'h0100);
    chk(irq == 1, "R11 ovf irq", 32'(irq), 1);

    // R12 FIFO resets
    wr(8, 1); wr(8, 2); wr(8, 3);
    rd(5, d); chk(d == 32'h0003_0008, "R12 levels", d, 32'h0003_0008);
    wr(4, 32'h8000_0000);
    rd(5, d); chk(d == 32'h0000_0008, "R12 tx reset", d, 32'h8);
    wr(4, 32'h0000_8000);
    rd(5, d); chk(d == 0, "R12 rx reset", d, 0);

    // R13 soft reset
    wr(1, 32'h0000_1107); wr(6, 5); wr(8, 9);
    wr(0, 32'h8000_0003);
    rd(0, d); chk(d == 0, "R13 gctl", d, 0);
    rd(1, d); chk(d == 0, "R13 xctl", d, 0);
    rd(2, d); chk(d == 0, "R13 ien", d, 0);
    rd(3, d); chk(d == 0, "R13 ista", d, 0);
    rd(5, d); chk(d == 0, "R13 fsta", d, 0);
    rd(6, d); chk(d == 0, "R13 bcnt", d, 0);
    chk(cs == 4'hF && irq == 0, "R13 pins", {cs, irq}, 32'h1E);

    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end
endmodule